// File: doc/BRIEF.md
# MESI Coherent Cache Line Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds a tag, one data word and one of four coherence states: Invalid, Shared, Exclusive or Modified. The policy is write-invalidate. The processor side issues read and write requests. The bus side is split into two paths. On the outbound path the controller requests the bus, waits for a grant and then issues one command. On the inbound path it watches the commands that other caches issue and updates its own lines to match.

The local sequencer has three named states.

- `S_IDLE` looks up the line.
  - A read that hits completes in the same cycle.
  - A write that hits an Exclusive or Modified line also completes in the same cycle.
  - A write to a Shared line goes to `S_ARB`.
  - A miss goes to `S_ARB`.
- `S_ARB` raises the bus request and holds it until the grant arrives. On the granted cycle it issues whichever command the line currently needs:
  - a write-back of a dirty victim, after which it stays in `S_ARB` to fetch the new line;
  - an invalidate, which completes the write and returns to `S_IDLE`;
  - a read fill or a read-for-ownership fill, which moves to `S_WAIT`.
- `S_WAIT` holds until the fill response arrives, installs the line and returns to `S_IDLE`.

The snoop path is combinational. When another cache reads a line held Modified, this block drives the dirty word onto the bus and demotes the line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: A read that hits a valid line with a matching tag raises `cpu_done` and `cpu_hit` in the cycle it is presented, returns the stored word on `cpu_rdata`, and does not raise `bus_req`.
- R2: A write that hits a line in Exclusive or Modified state completes in the same way, with no bus request. The line becomes Modified and holds the new word.
- R3: A write that hits a Shared line raises `bus_req`. On the granted cycle it drives the invalidate command (code 3) with `cpu_addr` and completes in that same cycle. The line becomes Modified.
- R4: A miss happens when the line is Invalid or its tag differs. It issues a read fill (code 1) for a read or a read-for-ownership fill (code 2) for a write. It completes in the cycle `bus_resp_valid` is high, and a read returns `bus_resp_data`. Code 0 means no command.
- R5: A snooped read-for-ownership (2) or invalidate (3) to a held address makes the line Invalid. The next local access to that address is a miss. If the snoop arrives while a Shared-line write waits for the bus, the write becomes a read-for-ownership fill.
- R6: A snooped read (1) or read-for-ownership (2) to a line held Modified raises `snp_flush` with the line's word on `snp_data`.
- R7: Once raised, `bus_req` stays high until `bus_gnt` is seen. `bus_cmd` is 0 in every cycle without a grant.
- R8: A read fill installs the line as Shared when `bus_resp_shared` is high, and as Exclusive otherwise. A write fill installs the line as Modified with `cpu_wdata`.
- R9: A snooped read to a line held Exclusive or Modified moves it to Shared, so a later local write needs an invalidate.
- R10: A miss whose victim line is Modified first issues a write-back (code 4) carrying the victim's address and word on `bus_addr` and `bus_wdata`, then issues the fill.
- R11: While `snp_valid` is high, a processor request waiting in `S_IDLE` is not accepted: `cpu_done` stays low.
- R12: `snp_shared` is high exactly when the snooped address is held in a valid state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address; the low bits are the index, the rest the tag |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion needed no bus traffic |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus request to the external arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 3 | Outbound command: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Outbound command address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_resp_valid | input | 1 | Fill response valid |
| bus_resp_data | input | DATA_W | Fill word |
| bus_resp_shared | input | 1 | Another cache also holds the filled line |
| snp_valid | input | 1 | A command from another cache is on the bus |
| snp_cmd | input | 3 | Snooped command code, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | Snooped address is held valid here |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
The assertions assume the bus is serialised:
- a snoop never arrives in the same cycle as this block's own granted command;
- no snoop targets the line that this block is filling in `S_WAIT`;
- the processor drops `cpu_req` the cycle after `cpu_done`.

The stimulus meets these assumptions by construction. It drives each processor operation as one transaction, raising the grant or the fill response only when the block is waiting for it. Snoops are injected only between operations, or during a deliberately delayed grant. The one exception is a single cycle that overlaps a snoop with an idle-state hit, to exercise R11.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDX  = 3'd2,
        CMD_UPG  = 3'd3,
        CMD_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARB  = 2'd1,
        S_WAIT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_st_we,
    input  logic              loc_tag_we,
    input  logic              loc_data_we,
    input  logic [IDX_W-1:0]  loc_idx,
    input  line_st_e          loc_st,
    input  logic [TAG_W-1:0]  loc_tag,
    input  logic [DATA_W-1:0] loc_data,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  line_st_e          snp_st,
    output line_st_e          st_o   [LINES],
    output logic [TAG_W-1:0]  tag_o  [LINES],
    output logic [DATA_W-1:0] data_o [LINES]
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel_loc, sel_snp;
        assign sel_loc = (loc_idx == IDX_W'(i));
        assign sel_snp = (snp_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_o[i]   <= ST_I;
                tag_o[i]  <= '0;
                data_o[i] <= '0;
            end else begin
                if (loc_st_we && sel_loc)      st_o[i] <= loc_st;
                else if (snp_we && sel_snp)    st_o[i] <= snp_st;
                if (loc_tag_we && sel_loc)     tag_o[i]  <= loc_tag;
                if (loc_data_we && sel_loc)    data_o[i] <= loc_data;
            end
        end
    end
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_st_e          st_i   [LINES],
    input  logic [TAG_W-1:0]  tag_i  [LINES],
    input  logic [DATA_W-1:0] data_i [LINES],
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data,
    output logic              upd_we,
    output logic [IDX_W-1:0]  upd_idx,
    output line_st_e          upd_st
);
    logic [TAG_W-1:0] s_tag;
    line_st_e         s_st;
    logic             held, is_rd, is_kill;

    always_comb begin
        upd_idx  = snp_addr[IDX_W-1:0];
        s_tag    = snp_addr[ADDR_W-1:IDX_W];
        s_st     = st_i[upd_idx];
        held     = snp_valid && (s_st != ST_I) && (tag_i[upd_idx] == s_tag);
        is_rd    = (snp_cmd == CMD_RD);
        is_kill  = (snp_cmd == CMD_RDX) || (snp_cmd == CMD_UPG);
        snp_shared = held;
        snp_flush  = held && (s_st == ST_M) && (is_rd || snp_cmd == CMD_RDX);
        snp_data   = data_i[upd_idx];
        upd_we     = held && (is_kill || (is_rd && s_st != ST_S));
        upd_st     = is_kill ? ST_I : ST_S;
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_resp_shared,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    seq_st_e state_q, state_d;

    line_st_e          st_arr   [LINES];
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    line_st_e          l_st;
    logic [TAG_W-1:0]  l_tag;
    logic [DATA_W-1:0] l_data;
    logic              hit, dirty_victim;
    bus_cmd_e          need_cmd;

    logic              ls_st_we, ls_tag_we, ls_data_we;
    line_st_e          ls_st;
    logic [DATA_W-1:0] ls_data;

    logic              sn_we;
    logic [IDX_W-1:0]  sn_idx;
    line_st_e          sn_st;

    always_comb begin
        idx          = cpu_addr[IDX_W-1:0];
        tag          = cpu_addr[ADDR_W-1:IDX_W];
        l_st         = st_arr[idx];
        l_tag        = tag_arr[idx];
        l_data       = data_arr[idx];
        hit          = (l_st != ST_I) && (l_tag == tag);
        dirty_victim = (l_st == ST_M) && (l_tag != tag);
        if (dirty_victim)      need_cmd = CMD_WB;
        else if (hit && cpu_we) need_cmd = CMD_UPG;
        else if (cpu_we)       need_cmd = CMD_RDX;
        else                   need_cmd = CMD_RD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_done   = 1'b0;
        cpu_hit    = 1'b0;
        cpu_rdata  = l_data;
        bus_req    = 1'b0;
        bus_cmd    = CMD_NONE;
        bus_addr   = cpu_addr;
        bus_wdata  = l_data;
        ls_st_we   = 1'b0;
        ls_tag_we  = 1'b0;
        ls_data_we = 1'b0;
        ls_st      = ST_M;
        ls_data    = cpu_wdata;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req && !snp_valid) begin
                    if (hit && (!cpu_we || l_st == ST_E || l_st == ST_M)) begin
                        cpu_done   = 1'b1;
                        cpu_hit    = 1'b1;
                        ls_st_we   = cpu_we;
                        ls_data_we = cpu_we;
                    end else begin
                        state_d = S_ARB;
                    end
                end
            end
            S_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd = need_cmd;
                    unique case (need_cmd)
                        CMD_WB: begin
                            bus_addr = {l_tag, idx};
                            ls_st_we = 1'b1;
                            ls_st    = ST_I;
                        end
                        CMD_UPG: begin
                            ls_st_we   = 1'b1;
                            ls_data_we = 1'b1;
                            cpu_done   = 1'b1;
                            state_d    = S_IDLE;
                        end
                        default: state_d = S_WAIT;
                    endcase
                end
            end
            S_WAIT: begin
                cpu_rdata = bus_resp_data;
                if (bus_resp_valid) begin
                    cpu_done   = 1'b1;
                    ls_st_we   = 1'b1;
                    ls_tag_we  = 1'b1;
                    ls_data_we = 1'b1;
                    ls_st      = cpu_we ? ST_M : (bus_resp_shared ? ST_S : ST_E);
                    ls_data    = cpu_we ? cpu_wdata : bus_resp_data;
                    state_d    = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .loc_st_we(ls_st_we), .loc_tag_we(ls_tag_we), .loc_data_we(ls_data_we),
        .loc_idx(idx), .loc_st(ls_st), .loc_tag(tag), .loc_data(ls_data),
        .snp_we(sn_we), .snp_idx(sn_idx), .snp_st(sn_st),
        .st_o(st_arr), .tag_o(tag_arr), .data_o(data_arr)
    );

    mesi_snoop_unit #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .st_i(st_arr), .tag_i(tag_arr), .data_i(data_arr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data),
        .upd_we(sn_we), .upd_idx(sn_idx), .upd_st(sn_st)
    );

    // assertions
    logic [IDX_W-1:0] a_sidx;
    logic             a_kill_hit;
    assign a_sidx     = snp_addr[IDX_W-1:0];
    assign a_kill_hit = snp_valid && (snp_cmd == CMD_RDX || snp_cmd == CMD_UPG)
                        && st_arr[a_sidx] != ST_I
                        && tag_arr[a_sidx] == snp_addr[ADDR_W-1:IDX_W];

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_write_leaves_modified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_we) |=> (st_arr[$past(idx)] == ST_M));

    assert_snoop_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        a_kill_hit |=> (st_arr[$past(a_sidx)] == ST_I));

    assert_flush_clears_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |=> (st_arr[$past(a_sidx)] != ST_M));

    assert_wb_then_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_WB) |=> bus_req);
endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic       cpu_req = 0, cpu_we = 0;
    logic [7:0] cpu_addr = 0, cpu_wdata = 0;
    logic       cpu_done, cpu_hit;
    logic [7:0] cpu_rdata;
    logic       bus_req, bus_gnt = 0;
    logic [2:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata;
    logic       bus_resp_valid = 0, bus_resp_shared = 0;
    logic [7:0] bus_resp_data = 0;
    logic       snp_valid = 0;
    logic [2:0] snp_cmd = 0;
    logic [7:0] snp_addr = 0;
    logic       snp_shared, snp_flush;
    logic [7:0] snp_data;

    int n_vec = 0, n_bad = 0;
    // behavioural model: 0 I, 1 S, 2 E, 3 M
    int m_st [4];
    int m_tag[4];
    int m_dat[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_line_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_resp_valid(bus_resp_valid),
        .bus_resp_data(bus_resp_data), .bus_resp_shared(bus_resp_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every clock: no command without grant (R7)
    always @(negedge clk) if (rst_n) begin
        #2;
        if (!bus_gnt) chk(bus_cmd == 3'd0, "R7 cmd without grant", bus_cmd, 0);
    end

    task automatic cpu_op(input bit we, input logic [7:0] addr, input logic [7:0] wd,
                          input logic [7:0] rsp, input bit sh, input int gdly,
                          input bit mid_snp, input string req);
        int ix, tg, dly, cyc, ecmd;
        bit waiting, done, ehit;
        ix = addr[1:0]; tg = addr[7:2];
        ehit = (m_st[ix] != 0 && m_tag[ix] == tg) && (!we || m_st[ix] >= 2);
        waiting = 0; done = 0; dly = gdly; cyc = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        while (!done && cyc < 40) begin
            #1;
            if (cpu_done) begin
                done = 1;
                chk(ehit && cpu_hit && !bus_req, {req, " hit path"}, cpu_hit, ehit);
                if (!we) chk(cpu_rdata == m_dat[ix][7:0], {req, " hit data"}, cpu_rdata, m_dat[ix]);
                if (we) begin m_st[ix] = 3; m_dat[ix] = wd; end
            end else if (waiting) begin
                bus_resp_valid = 1; bus_resp_data = rsp; bus_resp_shared = sh;
                #1;
                chk(cpu_done, {req, " fill done"}, cpu_done, 1);
                if (!we) chk(cpu_rdata == rsp, {req, " fill data"}, cpu_rdata, rsp);
                m_st[ix] = we ? 3 : (sh ? 1 : 2); m_tag[ix] = tg; m_dat[ix] = we ? wd : rsp;
                done = 1;
            end else if (bus_req) begin
                chk(!ehit, {req, " unexpected bus"}, 1, 0);
                if (dly > 0) begin
                    chk(!cpu_done, "R7 waits for grant", cpu_done, 0);
                    if (mid_snp && dly == gdly) begin
                        snp_valid = 1; snp_cmd = 3'd3; snp_addr = addr;
                        if (m_st[ix] != 0 && m_tag[ix] == tg) m_st[ix] = 0;
                    end
                    dly--;
                end else begin
                    bus_gnt = 1;
                    #1;
                    if (m_st[ix] == 3 && m_tag[ix] != tg) ecmd = 4;
                    else if (m_st[ix] != 0 && m_tag[ix] == tg && we) ecmd = 3;
                    else ecmd = we ? 2 : 1;
                    chk(bus_cmd == 3'(ecmd), {req, " bus cmd"}, bus_cmd, ecmd);
                    if (ecmd == 4) begin
                        chk(bus_addr == 8'({m_tag[ix][5:0], 2'(ix)}), "R10 wb addr", bus_addr, {m_tag[ix][5:0], 2'(ix)});
                        chk(bus_wdata == m_dat[ix][7:0], "R10 wb data", bus_wdata, m_dat[ix]);
                        m_st[ix] = 0;
                    end else begin
                        chk(bus_addr == addr, {req, " bus addr"}, bus_addr, addr);
                        if (ecmd == 3) begin
                            chk(cpu_done, "R3 upgrade completes", cpu_done, 1);
                            m_st[ix] = 3; m_dat[ix] = wd; done = 1;
                        end else waiting = 1;
                    end
                end
            end
            @(negedge clk);
            bus_gnt = 0; bus_resp_valid = 0; snp_valid = 0;
            cyc++;
        end
        chk(done, {req, " completion"}, done, 1);
        cpu_req = 0;
    endtask

    task automatic snoop(input logic [2:0] cmd, input logic [7:0] addr, input string req);
        int ix, tg;
        bit held, efl;
        ix = addr[1:0]; tg = addr[7:2];
        @(negedge clk);
        snp_valid = 1; snp_cmd = cmd; snp_addr = addr;
        #1;
        held = (m_st[ix] != 0 && m_tag[ix] == tg);
        efl  = held && m_st[ix] == 3 && (cmd == 3'd1 || cmd == 3'd2);
        chk(snp_shared == held, "R12 snoop presence", snp_shared, held);
        chk(snp_flush == efl, {req, " flush"}, snp_flush, efl);
        if (efl) chk(snp_data == m_dat[ix][7:0], "R6 flush data", snp_data, m_dat[ix]);
        if (held && cmd == 3'd1) m_st[ix] = 1;
        if (held && (cmd == 3'd2 || cmd == 3'd3)) m_st[ix] = 0;
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
        #(CLK_PERIOD*3);
        chk(!cpu_done && !bus_req && bus_cmd == 0, "R7 reset quiet", bus_req, 0);
        rst_n = 1;
        cpu_op(0, 8'h05, 0, 8'h11, 0, 0, 0, "R4 read miss");     // -> E (R8)
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0, "R1 read hit");
        cpu_op(1, 8'h05, 8'h22, 0, 0, 0, 0, "R2 write hit E");    // R8 exclusive
        snoop(3'd1, 8'h05, "R6 R9 snoop read on M");
        cpu_op(1, 8'h05, 8'h33, 0, 0, 3, 0, "R3 write on S");     // R9, R7 delayed grant
        snoop(3'd2, 8'h05, "R5 snoop rfo");
        cpu_op(0, 8'h05, 0, 8'h44, 1, 0, 0, "R5 R8 miss after kill");
        cpu_op(1, 8'h05, 8'h55, 8'h66, 0, 2, 1, "R5 upgrade lost to snoop");
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0, "R1 read own write");
        cpu_op(0, 8'h45, 0, 8'h77, 0, 1, 0, "R10 evict dirty");
        snoop(3'd1, 8'h09, "R12 snoop miss");
        cpu_op(1, 8'h02, 8'h88, 8'h99, 0, 0, 0, "R4 write miss");
        cpu_op(0, 8'h02, 0, 0, 0, 0, 0, "R8 write fill data");
        // R11: snoop blocks an idle-state hit for one cycle
        @(negedge clk);
        snp_valid = 1; snp_cmd = 3'd1; snp_addr = 8'hF3;
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h02;
        #1;
        chk(!cpu_done, "R11 snoop priority", cpu_done, 0);
        @(negedge clk);
        snp_valid = 0;
        #1;
        chk(cpu_done && cpu_rdata == 8'h88, "R11 served after snoop", cpu_rdata, 8'h88);
        @(negedge clk);
        cpu_req = 0;
        snoop(3'd3, 8'h45, "R5 invalidate E line");
        cpu_op(0, 8'h45, 0, 8'hAB, 0, 0, 0, "R5 miss after invalidate");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*20000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule